// File: doc/BRIEF.md
# RGB to Grayscale Pixel Converter

This block turns one colour sample, carried as three 16-bit channels, into a 32-bit packed pixel word. When the per-sample grayscale flag is set, it forms a luminance-weighted level from the three channels. The weights are the integers 77, 151 and 28 out of 256 for red, green and blue. A rounding bias of 127 is added and the sum is shifted right by 8 to give a 16-bit gray level. That level then replaces all three channels. When the flag is clear, the channels pass through unchanged.

Each resulting channel is cut to its top 8 bits and packed into the output word. The word carries red in the upper byte lane, then green, then blue. The block has a valid/ready stream on both sides and two register stages: a multiply-accumulate stage followed by a reduce-and-pack stage. Backpressure from the output propagates back to the input without losing or reordering samples.

Top module: `rgb_gray_conv`

## Requirements
- R1: The gray level is (R*77 + G*151 + B*28 + 127) >> 8, kept as a 16-bit value; the +127 bias is applied before the shift (blue-only input 2337 gives gray 256, while 2336 gives 255).
- R2: With `in_gray` = 1, the red, green and blue fields of the output word all hold bits 15:8 of the gray level.
- R3: With `in_gray` = 0, each output field holds bits 15:8 of the matching input channel.
- R4: The output word carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: Bits 31:24 of the output word are always zero.
- R6: The weighted sum cannot overflow: all three channels at 0xFFFF in grayscale mode give 0x00FFFFFF.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pixel` stays unchanged.
- R8: A sample accepted on clock edge k appears on `out_valid` after edge k+1 when the output is not stalled. With the output stalled, the block accepts exactly two samples and then lowers `in_ready`. Samples leave in the order they arrived, and none is lost.
- R9: During and right after synchronous reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_red | input | 16 | Red channel |
| in_green | input | 16 | Green channel |
| in_blue | input | 16 | Blue channel |
| in_gray | input | 1 | 1 = replace channels by the gray level for this sample |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word this cycle |
| out_pixel | output | 32 | Packed pixel: zero, red, green, blue byte lanes |

## Verification
The hardest state to reach from the ports is a full pipeline under a stalled output, where `in_ready` must drop after exactly two accepted samples and the held word must not move. The stimulus reaches it by holding `out_ready` low, pushing two samples, and then watching `in_ready` and `out_pixel` for several cycles before releasing. A second stretch toggles `out_ready` pseudo-randomly while the driver streams mixed-mode samples, so stalls land in every phase of the handshake. The rounding bias is pinned by a blue-only pair of inputs that straddle the point where the bias alone carries the gray level into the next output code.

// File: rtl/rgbg_pkg.sv
// Package: shared widths, luminance weights and types for the RGB to gray converter.
// Assumes the weights sum to at most 2**NORM_SH so the normalised level fits CH_W bits.
package rgbg_pkg;
    localparam int CH_W    = 16;   // input channel width
    localparam int OUT_W   = 8;    // packed channel width
    localparam int PIX_W   = 32;   // packed word width
    localparam int W_RED   = 77;
    localparam int W_GREEN = 151;
    localparam int W_BLUE  = 28;
    localparam int BIAS    = 127;
    localparam int NORM_SH = 8;
    localparam int N_CH    = 3;
    // sum width: channel width plus enough bits for the weight total
    localparam int SUM_W   = CH_W + $clog2(W_RED + W_GREEN + W_BLUE + 1);

    typedef logic [CH_W-1:0] chan_t;
endpackage

// File: rtl/rgbg_mac_stage.sv
// Stage 1: weighted multiply-accumulate with rounding bias.
// Registers the biased luminance sum, the raw channels and the mode flag.
// Assumes down_ready comes from the next stage's combinational ready.
module rgbg_mac_stage
    import rgbg_pkg::*;
#(
    parameter int CW  = CH_W,
    parameter int SW  = SUM_W,
    parameter int WR  = W_RED,
    parameter int WG  = W_GREEN,
    parameter int WB  = W_BLUE,
    parameter int BS  = BIAS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] in_red,
    input  logic [CW-1:0] in_green,
    input  logic [CW-1:0] in_blue,
    input  logic          in_gray,
    input  logic          down_ready,
    output logic          s1_valid,
    output logic [SW-1:0] s1_sum,
    output logic [CW-1:0] s1_red,
    output logic [CW-1:0] s1_green,
    output logic [CW-1:0] s1_blue,
    output logic          s1_gray
);
    logic [SW-1:0] sum_d;

    // Stage may load when empty or when its content moves on
    assign in_ready = !s1_valid || down_ready;

    // Weighted sum plus rounding bias, computed at full width
    always_comb begin
        sum_d = SW'(in_red)   * SW'(WR)
              + SW'(in_green) * SW'(WG)
              + SW'(in_blue)  * SW'(WB)
              + SW'(BS);
    end

    // Valid flag tracks occupancy of this stage
    always_ff @(posedge clk) begin
        if (!rst_n)        s1_valid <= 1'b0;
        else if (in_ready) s1_valid <= in_valid;
    end

    // Capture sum, raw channels and mode on an accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sum   <= '0;
            s1_red   <= '0;
            s1_green <= '0;
            s1_blue  <= '0;
            s1_gray  <= 1'b0;
        end else if (in_valid && in_ready) begin
            s1_sum   <= sum_d;
            s1_red   <= in_red;
            s1_green <= in_green;
            s1_blue  <= in_blue;
            s1_gray  <= in_gray;
        end
    end

    AST_S1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && !down_ready |=> s1_valid && $stable(s1_sum)); // R8
    AST_S1_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> s1_valid); // R8
endmodule

// File: rtl/rgbg_pack_stage.sv
// Stage 2: normalise the sum, choose gray or raw channels, cut each to its
// top bits and pack them into the output word with the upper lane zeroed.
// Assumes channel index 0 = blue (lowest lane), 2 = red (highest lane).
module rgbg_pack_stage
    import rgbg_pkg::*;
#(
    parameter int CW  = CH_W,
    parameter int SW  = SUM_W,
    parameter int OW  = OUT_W,
    parameter int PW  = PIX_W,
    parameter int SH  = NORM_SH,
    parameter int NC  = N_CH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s1_valid,
    output logic          up_ready,
    input  logic [SW-1:0] s1_sum,
    input  logic [CW-1:0] s1_red,
    input  logic [CW-1:0] s1_green,
    input  logic [CW-1:0] s1_blue,
    input  logic          s1_gray,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] out_pixel
);
    localparam int PAD_W = PW - NC*OW;

    logic [CW-1:0]    gray_lvl;
    logic [CW-1:0]    raw_ch [NC];
    logic [NC*OW-1:0] lanes;
    logic             gray_q;

    // Stage may load when empty or when the consumer takes the word
    assign up_ready = !out_valid || out_ready;

    // Normalised 16-bit luminance level
    assign gray_lvl = CW'(s1_sum >> SH);

    assign raw_ch[0] = s1_blue;
    assign raw_ch[1] = s1_green;
    assign raw_ch[2] = s1_red;

    // One reducer per channel: pick source, keep its top OW bits
    for (genvar c = 0; c < NC; c++) begin : g_lane
        logic [CW-1:0] src;
        assign src = s1_gray ? gray_lvl : raw_ch[c];
        assign lanes[c*OW +: OW] = src[CW-1 -: OW];
    end

    // Valid flag tracks occupancy of the output register
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (up_ready) out_valid <= s1_valid;
    end

    // Capture packed word and its mode on a transfer from stage 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pixel <= '0;
            gray_q    <= 1'b0;
        end else if (s1_valid && up_ready) begin
            out_pixel <= {{PAD_W{1'b0}}, lanes};
            gray_q    <= s1_gray;
        end
    end

    AST_GRAY_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && gray_q |->
            out_pixel[2*OW +: OW] == out_pixel[OW +: OW] &&
            out_pixel[OW +: OW]   == out_pixel[0 +: OW]); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel)); // R7
endmodule

// File: rtl/rgb_gray_conv.sv
// Top: two-stage streaming RGB to grayscale converter with packed output.
// Stage 1 accumulates the weighted luminance, stage 2 reduces and packs.
// Ready ripples back combinationally; each stage holds one sample.
module rgb_gray_conv
    import rgbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CH_W-1:0]  in_red,
    input  logic [CH_W-1:0]  in_green,
    input  logic [CH_W-1:0]  in_blue,
    input  logic             in_gray,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pixel
);
    logic             s1_valid;
    logic             s2_ready;
    logic [SUM_W-1:0] s1_sum;
    logic [CH_W-1:0]  s1_red;
    logic [CH_W-1:0]  s1_green;
    logic [CH_W-1:0]  s1_blue;
    logic             s1_gray;

    rgbg_mac_stage u_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_red     (in_red),
        .in_green   (in_green),
        .in_blue    (in_blue),
        .in_gray    (in_gray),
        .down_ready (s2_ready),
        .s1_valid   (s1_valid),
        .s1_sum     (s1_sum),
        .s1_red     (s1_red),
        .s1_green   (s1_green),
        .s1_blue    (s1_blue),
        .s1_gray    (s1_gray)
    );

    rgbg_pack_stage u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .up_ready  (s2_ready),
        .s1_sum    (s1_sum),
        .s1_red    (s1_red),
        .s1_green  (s1_green),
        .s1_blue   (s1_blue),
        .s1_gray   (s1_gray),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pixel (out_pixel)
    );

    AST_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pixel[PIX_W-1:N_CH*OUT_W] == '0); // R5
endmodule

// File: tb/rgb_gray_conv_tb.sv
module rgb_gray_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_red = '0, in_green = '0, in_blue = '0;
    logic        in_gray = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_pixel;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rand_bp = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_2B5D;

    always #4 clk = ~clk; // 125 MHz

    rgb_gray_conv u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue), .in_gray(in_gray),
        .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
    );

    function automatic logic [31:0] model(input logic [15:0] r, g, b, input logic m);
        int unsigned s;
        logic [15:0] gl;
        s  = r * 77 + g * 151 + b * 28 + 127;
        gl = 16'(s >> 8);
        if (m) return {8'h00, gl[15:8], gl[15:8], gl[15:8]};
        return {8'h00, r[15:8], g[15:8], b[15:8]};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Driver: present a sample, push its expected word, wait for acceptance
    task automatic send(input logic [15:0] r, g, b, input logic m, input string req);
        logic hs;
        exp_q.push_back(model(r, g, b, m));
        tag_q.push_back(req);
        in_red = r; in_green = g; in_blue = b; in_gray = m; in_valid = 1'b1;
        do begin
            @(negedge clk);
            hs = in_ready;
            @(posedge clk);
            #1;
        end while (!hs);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(posedge clk);
            guard++;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Monitor: pop and compare on every output transfer
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected output", out_pixel, 32'hxxxxxxxx);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_pixel, e);
            end
        end
    end

    // Random backpressure generator
    always @(posedge clk) begin
        if (rand_bp) begin
            #1;
            lfsr = next_rand(lfsr);
            out_ready = lfsr[3] | lfsr[7];
        end
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 out_valid in reset", {31'b0, out_valid}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 out_valid after reset", {31'b0, out_valid}, 32'd0);
        check("R9 in_ready after reset", {31'b0, in_ready}, 32'd1);

        @(posedge clk); #1;
        out_ready = 1'b1;

        // R8: latency of two edges
        send(16'h1234, 16'h5678, 16'h9ABC, 1'b0, "R3 colour passthrough");
        @(negedge clk);
        check("R8 not yet valid one edge after accept", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check("R8 valid two edges after accept", {31'b0, out_valid}, 32'd1);
        drain();

        // R1: rounding bias boundary, blue only
        send(16'd0, 16'd0, 16'd2337, 1'b1, "R1 bias carries to 256");
        send(16'd0, 16'd0, 16'd2336, 1'b1, "R1 just below 256");
        send(16'h8080, 16'h8080, 16'h8080, 1'b1, "R1 equal channels");
        // R4: lane positions, colour mode
        send(16'hAB00, 16'h0000, 16'h0000, 1'b0, "R4 red lane");
        send(16'h0000, 16'hCD00, 16'h0000, 1'b0, "R4 green lane");
        send(16'h0000, 16'h0000, 16'hEF00, 1'b0, "R4 blue lane");
        // R2: gray replaces channels
        send(16'hFF00, 16'h0000, 16'h0000, 1'b1, "R2 red only gray");
        send(16'h0000, 16'hFF00, 16'h0000, 1'b1, "R2 green only gray");
        // R6: overflow corner
        send(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, "R6 all max gray");
        send(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, "R5 all max colour");
        send(16'h00FF, 16'h00FF, 16'h00FF, 1'b0, "R3 low byte dropped");
        drain();

        // R7 / R8: stalled output, pipeline fills with two samples
        out_ready = 1'b0;
        send(16'h1111, 16'h2222, 16'h3333, 1'b1, "R8 stalled first");
        send(16'h4444, 16'h5555, 16'h6666, 1'b0, "R8 stalled second");
        @(negedge clk);
        check("R8 in_ready low when full", {31'b0, in_ready}, 32'd0);
        held = out_pixel;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R7 out_valid held", {31'b0, out_valid}, 32'd1);
            check("R7 out_pixel held", out_pixel, held);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();

        // R8: random backpressure, mixed modes, order preserved
        rand_bp = 1'b1;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a, b2;
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b2 = lfsr;
            send(a[15:0], a[31:16], b2[15:0], b2[20], "R8 random stream");
        end
        rand_bp = 1'b0;
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();
        check("R8 all samples delivered", 32'(exp_q.size()), 32'd0);

        finish_run();
    end
endmodule